// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This unit resolves the second source operand of a register-destination add and then writes the sum back. It takes a decoded mode code, three register specifiers and a constant field. It reads the operand from an internal register file, from the constant itself, or from an internal word memory. The memory is reached through a one-cycle request and a one-cycle data return. Some modes also change a pointer register as a side effect. When the operand is resolved, the unit raises a one-cycle completion pulse, presents the operand, and updates the destination register with destination plus operand.

All values are `WORD_W` bits wide, and memory addresses use the same width, so every address and pointer computation wraps modulo 2^`WORD_W`. The element size `ELEM_BYTES` must be a power of two. It sets the pointer step and the index scale. Load ports let the surrounding logic preset registers and memory words. A view port reads any register combinationally.

Top module: `operand_fetch_unit`

## Requirements
- R1: Mode 0 (register) uses R[base] as the operand and mode 1 (immediate) uses the constant. Both write R[dst] = R[dst] + operand. `done` rises 2 cycles after the accepting edge.
- R2: Mode 2 reads Mem[const + R[base]]. Mode 3 reads Mem[R[base]]. Mode 4 reads Mem[R[base] + R[index]]. Mode 5 reads Mem[const]. Each issues one memory request, and `done` comes 3 cycles after acceptance. The memory returns data in the cycle after a request.
- R3: Mode 6 reads Mem[R[base]] and uses the returned word as the address of a second read. The operand is Mem[Mem[R[base]]], and `done` comes 4 cycles after acceptance.
- R4: Mode 7 reads Mem[R[base]] and afterwards adds ELEM_BYTES to R[base]. `done` comes 3 cycles after acceptance.
- R5: Mode 8 first subtracts ELEM_BYTES from R[base] and then reads Mem at the decremented value. `done` comes 3 cycles after acceptance.
- R6: Mode 9 reads Mem[const + R[base] + R[index]*ELEM_BYTES]. `done` comes 3 cycles after acceptance.
- R7: When the mode 7 or mode 8 pointer register is also the destination, the pointer update is applied first. The sum is then formed from the updated value and written last.
- R8: Mode codes 10 to 15 give `illegal` high together with `done`, 2 cycles after acceptance. No register changes.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. A `start` seen while busy is ignored, and fields changed while busy have no effect on the running instruction.
- R10: Address and pointer arithmetic wraps modulo 2^WORD_W.
- R11: `done` is a single-cycle pulse. `operand` holds the fetched value while `done` is high for a legal mode.
- R12: After reset, `busy`, `done` and `illegal` are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin an instruction; taken only when idle |
| modeCode | input | 4 | Addressing mode code 0..15 |
| dstIdx | input | REG_IDX_W | Destination register |
| baseIdx | input | REG_IDX_W | Base / pointer / operand register |
| indexIdx | input | REG_IDX_W | Index register |
| konst | input | WORD_W | Constant, displacement or absolute address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Mode code was undefined, valid with done |
| operand | output | WORD_W | Fetched operand |
| regLoadEn | input | 1 | Preset write to a register |
| regLoadIdx | input | REG_IDX_W | Register to preset |
| regLoadData | input | WORD_W | Preset value |
| regViewIdx | input | REG_IDX_W | Register to view |
| regViewData | output | WORD_W | Value of the viewed register |
| memLoadEn | input | 1 | Preset write to memory |
| memLoadAddr | input | WORD_W | Memory word to preset |
| memLoadData | input | WORD_W | Preset memory value |

## Verification
The hardest case to reach is the one where the pointer register of modes 7 and 8 is also the destination. Here the pointer write and the sum write go to the same register in different cycles, and their order decides the final value. The stimulus drives both of these modes with the destination equal to the base, starting from a pointer value chosen so that the step also wraps past zero. A second hard case is a new `start` with different fields arriving mid-instruction. The bench holds `start` high with unrelated fields for the whole busy window and then checks that the timing, the operand and all registers match the first instruction alone.

// File: rtl/ofu_pkg.sv
package ofu_pkg;

  typedef enum logic [3:0] {
    MODE_REG     = 4'd0,
    MODE_IMM     = 4'd1,
    MODE_DISP    = 4'd2,
    MODE_REGIND  = 4'd3,
    MODE_INDEX   = 4'd4,
    MODE_ABS     = 4'd5,
    MODE_MEMIND  = 4'd6,
    MODE_POSTINC = 4'd7,
    MODE_PREDEC  = 4'd8,
    MODE_SCALED  = 4'd9
  } mode_e;

  typedef enum logic [2:0] {
    EA_BASE_CONST,
    EA_BASE,
    EA_BASE_INDEX,
    EA_CONST,
    EA_CHAIN,
    EA_BASE_DEC,
    EA_SCALED
  } ea_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_CHAIN,
    ST_DATA,
    ST_WB
  } state_e;

  typedef struct packed {
    logic latch;
    logic memReq;
    ea_e  eaSel;
    logic takeReg;
    logic takeConst;
    logic takeMem;
    logic ptrWrite;
    logic ptrDown;
    logic sumWrite;
  } strobe_t;

endpackage

// File: rtl/ofu_regfile.sv
module ofu_regfile #(
  parameter int WORD_W = 8,
  parameter int REG_N  = 8,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [WORD_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [WORD_W-1:0] rdDataB,
  input  logic [IDX_W-1:0]  rdIdxC,
  output logic [WORD_W-1:0] rdDataC,
  input  logic [IDX_W-1:0]  rdIdxD,
  output logic [WORD_W-1:0] rdDataD,
  input  logic              unitWe,
  input  logic [IDX_W-1:0]  unitIdx,
  input  logic [WORD_W-1:0] unitData,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [WORD_W-1:0] loadData
);

  logic [WORD_W-1:0] regs [REG_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_N; i++) regs[i] <= '0;
    end else if (unitWe) begin
      regs[unitIdx] <= unitData;
    end else if (loadEn) begin
      regs[loadIdx] <= loadData;
    end
  end

  assign rdDataA = regs[rdIdxA];
  assign rdDataB = regs[rdIdxB];
  assign rdDataC = regs[rdIdxC];
  assign rdDataD = regs[rdIdxD];

endmodule

// File: rtl/ofu_wordmem.sv
module ofu_wordmem #(
  parameter int WORD_W = 8,
  localparam int DEPTH = 1 << WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic [WORD_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  input  logic              loadEn,
  input  logic [WORD_W-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData
);

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (loadEn) cells[loadAddr] <= loadData;
    if (rdReq) rdData <= cells[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdReq;
  end

endmodule

// File: rtl/ofu_ctrl.sv
module ofu_ctrl
  import ofu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] curMode,
  output strobe_t    stb,
  output logic       busy,
  output logic       done,
  output logic       illegal
);

  state_e state, stateNext;
  logic   illegalQ, illegalSet;

  always_comb begin
    stb        = '0;
    stb.eaSel  = EA_BASE;
    stateNext  = state;
    illegalSet = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.latch = 1'b1;
          stateNext = ST_EXEC;
        end
      end
      ST_EXEC: begin
        stateNext = ST_DATA;
        case (curMode)
          MODE_REG: begin
            stb.takeReg = 1'b1;
            stateNext   = ST_WB;
          end
          MODE_IMM: begin
            stb.takeConst = 1'b1;
            stateNext     = ST_WB;
          end
          MODE_DISP: begin
            stb.memReq = 1'b1;
            stb.eaSel  = EA_BASE_CONST;
          end
          MODE_REGIND, MODE_POSTINC: begin
            stb.memReq = 1'b1;
            stb.eaSel  = EA_BASE;
          end
          MODE_INDEX: begin
            stb.memReq = 1'b1;
            stb.eaSel  = EA_BASE_INDEX;
          end
          MODE_ABS: begin
            stb.memReq = 1'b1;
            stb.eaSel  = EA_CONST;
          end
          MODE_MEMIND: begin
            stb.memReq = 1'b1;
            stb.eaSel  = EA_BASE;
            stateNext  = ST_CHAIN;
          end
          MODE_PREDEC: begin
            stb.memReq   = 1'b1;
            stb.eaSel    = EA_BASE_DEC;
            stb.ptrWrite = 1'b1;
            stb.ptrDown  = 1'b1;
          end
          MODE_SCALED: begin
            stb.memReq = 1'b1;
            stb.eaSel  = EA_SCALED;
          end
          default: begin
            illegalSet = 1'b1;
            stateNext  = ST_WB;
          end
        endcase
      end
      ST_CHAIN: begin
        stb.memReq = 1'b1;
        stb.eaSel  = EA_CHAIN;
        stateNext  = ST_DATA;
      end
      ST_DATA: begin
        stb.takeMem = 1'b1;
        if (curMode == MODE_POSTINC) stb.ptrWrite = 1'b1;
        stateNext = ST_WB;
      end
      ST_WB: begin
        stb.sumWrite = !illegalQ;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      illegalQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.latch)      illegalQ <= 1'b0;
      else if (illegalSet) illegalQ <= 1'b1;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_WB);
  assign illegal = done && illegalQ;

endmodule

// File: rtl/ofu_datapath.sv
module ofu_datapath
  import ofu_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int REG_N      = 8,
  parameter int ELEM_BYTES = 4,
  localparam int IDX_W     = $clog2(REG_N),
  localparam int SCALE_SH  = $clog2(ELEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [3:0]        modeIn,
  input  logic [IDX_W-1:0]  dstIn,
  input  logic [IDX_W-1:0]  baseIn,
  input  logic [IDX_W-1:0]  indexIn,
  input  logic [WORD_W-1:0] konstIn,
  input  logic [WORD_W-1:0] memRdData,
  output logic [3:0]        curMode,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] operand,
  output logic              unitWe,
  input  logic              regLoadEn,
  input  logic [IDX_W-1:0]  regLoadIdx,
  input  logic [WORD_W-1:0] regLoadData,
  input  logic [IDX_W-1:0]  regViewIdx,
  output logic [WORD_W-1:0] regViewData
);

  localparam logic [WORD_W-1:0] STEP = WORD_W'(ELEM_BYTES);

  logic [3:0]        modeQ;
  logic [IDX_W-1:0]  dstQ, baseQ, indexQ;
  logic [WORD_W-1:0] konstQ, operandQ;
  logic [WORD_W-1:0] baseVal, indexVal, dstVal;
  logic [WORD_W-1:0] decVal, incVal, ea;
  logic [IDX_W-1:0]  wIdx;
  logic [WORD_W-1:0] wData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      dstQ   <= '0;
      baseQ  <= '0;
      indexQ <= '0;
      konstQ <= '0;
    end else if (stb.latch) begin
      modeQ  <= modeIn;
      dstQ   <= dstIn;
      baseQ  <= baseIn;
      indexQ <= indexIn;
      konstQ <= konstIn;
    end
  end

  assign decVal = baseVal - STEP;
  assign incVal = baseVal + STEP;

  always_comb begin
    case (stb.eaSel)
      EA_BASE_CONST: ea = konstQ + baseVal;
      EA_BASE:       ea = baseVal;
      EA_BASE_INDEX: ea = baseVal + indexVal;
      EA_CONST:      ea = konstQ;
      EA_CHAIN:      ea = memRdData;
      EA_BASE_DEC:   ea = decVal;
      EA_SCALED:     ea = konstQ + baseVal + (indexVal << SCALE_SH);
      default:       ea = baseVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              operandQ <= '0;
    else if (stb.takeReg)   operandQ <= baseVal;
    else if (stb.takeConst) operandQ <= konstQ;
    else if (stb.takeMem)   operandQ <= memRdData;
  end

  assign unitWe = stb.ptrWrite || stb.sumWrite;
  assign wIdx   = stb.ptrWrite ? baseQ : dstQ;
  assign wData  = stb.ptrWrite ? (stb.ptrDown ? decVal : incVal)
                               : (dstVal + operandQ);

  ofu_regfile #(.WORD_W(WORD_W), .REG_N(REG_N)) u_rf (
    .clk      (clk),
    .rstN     (rstN),
    .rdIdxA   (baseQ),
    .rdDataA  (baseVal),
    .rdIdxB   (indexQ),
    .rdDataB  (indexVal),
    .rdIdxC   (dstQ),
    .rdDataC  (dstVal),
    .rdIdxD   (regViewIdx),
    .rdDataD  (regViewData),
    .unitWe   (unitWe),
    .unitIdx  (wIdx),
    .unitData (wData),
    .loadEn   (regLoadEn),
    .loadIdx  (regLoadIdx),
    .loadData (regLoadData)
  );

  assign curMode = modeQ;
  assign memAddr = ea;
  assign operand = operandQ;

endmodule

// File: rtl/operand_fetch_unit.sv
module operand_fetch_unit
  import ofu_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int REG_N      = 8,
  parameter int ELEM_BYTES = 4,
  localparam int REG_IDX_W = $clog2(REG_N)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [3:0]           modeCode,
  input  logic [REG_IDX_W-1:0] dstIdx,
  input  logic [REG_IDX_W-1:0] baseIdx,
  input  logic [REG_IDX_W-1:0] indexIdx,
  input  logic [WORD_W-1:0]    konst,
  output logic                 busy,
  output logic                 done,
  output logic                 illegal,
  output logic [WORD_W-1:0]    operand,
  input  logic                 regLoadEn,
  input  logic [REG_IDX_W-1:0] regLoadIdx,
  input  logic [WORD_W-1:0]    regLoadData,
  input  logic [REG_IDX_W-1:0] regViewIdx,
  output logic [WORD_W-1:0]    regViewData,
  input  logic                 memLoadEn,
  input  logic [WORD_W-1:0]    memLoadAddr,
  input  logic [WORD_W-1:0]    memLoadData
);

  strobe_t           stb;
  logic [3:0]        curMode;
  logic [WORD_W-1:0] memAddr, memRdData;
  logic              memReq, memValid, unitWe;

  assign memReq = stb.memReq;

  ofu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .curMode (curMode),
    .stb     (stb),
    .busy    (busy),
    .done    (done),
    .illegal (illegal)
  );

  ofu_datapath #(.WORD_W(WORD_W), .REG_N(REG_N), .ELEM_BYTES(ELEM_BYTES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .modeIn      (modeCode),
    .dstIn       (dstIdx),
    .baseIn      (baseIdx),
    .indexIn     (indexIdx),
    .konstIn     (konst),
    .memRdData   (memRdData),
    .curMode     (curMode),
    .memAddr     (memAddr),
    .operand     (operand),
    .unitWe      (unitWe),
    .regLoadEn   (regLoadEn),
    .regLoadIdx  (regLoadIdx),
    .regLoadData (regLoadData),
    .regViewIdx  (regViewIdx),
    .regViewData (regViewData)
  );

  ofu_wordmem #(.WORD_W(WORD_W)) u_mem (
    .clk      (clk),
    .rstN     (rstN),
    .rdReq    (memReq),
    .rdAddr   (memAddr),
    .rdValid  (memValid),
    .rdData   (memRdData),
    .loadEn   (memLoadEn),
    .loadAddr (memLoadAddr),
    .loadData (memLoadData)
  );

endmodule

// File: rtl/ofu_checker.sv
module ofu_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic illegal,
  input logic memReq,
  input logic memValid,
  input logic unitWe
);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_accept_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_no_req_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  assert_mem_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> memValid);

  assert_illegal_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done);

  assert_illegal_no_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !unitWe);

endmodule

bind operand_fetch_unit ofu_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .illegal  (illegal),
  .memReq   (memReq),
  .memValid (memValid),
  .unitWe   (unitWe)
);

// File: tb/tb_operand_fetch_unit.sv
module tb_operand_fetch_unit;

  localparam int WORD_W = 8;
  localparam int REG_N  = 8;
  localparam int EB     = 4;
  localparam int IW     = $clog2(REG_N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] modeCode = '0;
  logic [IW-1:0] dstIdx = '0, baseIdx = '0, indexIdx = '0;
  logic [WORD_W-1:0] konst = '0;
  logic busy, done, illegal;
  logic [WORD_W-1:0] operand;
  logic regLoadEn = 1'b0;
  logic [IW-1:0] regLoadIdx = '0;
  logic [WORD_W-1:0] regLoadData = '0;
  logic [IW-1:0] regViewIdx = '0;
  logic [WORD_W-1:0] regViewData;
  logic memLoadEn = 1'b0;
  logic [WORD_W-1:0] memLoadAddr = '0, memLoadData = '0;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  logic [WORD_W-1:0] refReg [REG_N];
  logic [WORD_W-1:0] refMem [1 << WORD_W];

  always #5 clk = ~clk;

  operand_fetch_unit #(.WORD_W(WORD_W), .REG_N(REG_N), .ELEM_BYTES(EB)) dut (
    .clk(clk), .rstN(rstN), .start(start), .modeCode(modeCode),
    .dstIdx(dstIdx), .baseIdx(baseIdx), .indexIdx(indexIdx), .konst(konst),
    .busy(busy), .done(done), .illegal(illegal), .operand(operand),
    .regLoadEn(regLoadEn), .regLoadIdx(regLoadIdx), .regLoadData(regLoadData),
    .regViewIdx(regViewIdx), .regViewData(regViewData),
    .memLoadEn(memLoadEn), .memLoadAddr(memLoadAddr), .memLoadData(memLoadData)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic putReg(input int idx, input logic [WORD_W-1:0] val);
    @(negedge clk);
    regLoadEn = 1'b1; regLoadIdx = IW'(idx); regLoadData = val;
    @(negedge clk);
    regLoadEn = 1'b0;
    refReg[idx] = val;
  endtask

  task automatic checkRegs(input string tag);
    for (int i = 0; i < REG_N; i++) begin
      regViewIdx = IW'(i);
      #1;
      chk(tag, regViewData, refReg[i]);
    end
  endtask

  // Drives one instruction and compares busy/done on every clock against
  // a behavioural model; jam holds start high with other fields while busy.
  task automatic runInsn(input string tag, input int m, input int d, input int b,
                         input int x, input logic [WORD_W-1:0] k, input bit jam);
    logic [WORD_W-1:0] op, a, r;
    bit bad;
    int lat;
    bad = 1'b0; op = '0;
    case (m)
      0: op = refReg[b];
      1: op = k;
      2: begin a = k + refReg[b]; op = refMem[a]; end
      3: op = refMem[refReg[b]];
      4: begin a = refReg[b] + refReg[x]; op = refMem[a]; end
      5: op = refMem[k];
      6: begin a = refMem[refReg[b]]; op = refMem[a]; end
      7: begin op = refMem[refReg[b]]; refReg[b] = refReg[b] + WORD_W'(EB); end
      8: begin refReg[b] = refReg[b] - WORD_W'(EB); op = refMem[refReg[b]]; end
      9: begin r = refReg[x] * WORD_W'(EB); a = k + refReg[b] + r; op = refMem[a]; end
      default: bad = 1'b1;
    endcase
    if (!bad) refReg[d] = refReg[d] + op;
    lat = (m <= 1 || bad) ? 2 : (m == 6 ? 4 : 3);

    @(negedge clk);
    start = 1'b1; modeCode = 4'(m); dstIdx = IW'(d); baseIdx = IW'(b);
    indexIdx = IW'(x); konst = k;
    for (int n = 1; n <= lat + 1; n++) begin
      @(negedge clk);
      if (n == 1) begin
        if (jam) begin
          modeCode = 4'(m ^ 1); dstIdx = IW'(d + 1); baseIdx = IW'(x);
          indexIdx = IW'(b); konst = ~k;
        end else start = 1'b0;
      end
      if (n == lat) start = 1'b0;
      chk({tag, " busy (R9)"}, busy, (n <= lat));
      chk({tag, " done timing (R11)"}, done, (n == lat));
      if (n == lat) begin
        chk({tag, " illegal flag"}, illegal, bad);
        if (!bad) chk({tag, " operand (R11)"}, operand, op);
      end
    end
    checkRegs({tag, " registers"});
  endtask

  initial begin
    for (int i = 0; i < REG_N; i++) refReg[i] = '0;
    repeat (3) @(negedge clk);
    chk("R12 busy after reset", busy, 0);
    chk("R12 done after reset", done, 0);
    chk("R12 illegal after reset", illegal, 0);
    checkRegs("R12 registers zero");
    rstN = 1'b1;

    for (int a = 0; a < (1 << WORD_W); a++) begin
      @(negedge clk);
      memLoadEn = 1'b1; memLoadAddr = WORD_W'(a);
      memLoadData = WORD_W'(a * 37 + 11);
      refMem[a] = WORD_W'(a * 37 + 11);
    end
    @(negedge clk);
    memLoadEn = 1'b0;

    putReg(0, 8'h10); putReg(1, 8'h24); putReg(2, 8'h40); putReg(3, 8'h03);
    putReg(4, 8'h05); putReg(5, 8'hFE); putReg(6, 8'h81); putReg(7, 8'h02);

    runInsn("R1 register mode",  0, 4, 3, 0, 8'h00, 1'b0);
    runInsn("R1 immediate mode", 1, 4, 0, 0, 8'h03, 1'b0);
    runInsn("R2 displacement",   2, 0, 1, 0, 8'h64, 1'b0);
    runInsn("R2 register indirect", 3, 7, 2, 0, 8'h00, 1'b0);
    runInsn("R2 indexed",        4, 3, 1, 2, 8'h00, 1'b0);
    runInsn("R2 absolute",       5, 6, 0, 0, 8'hE9, 1'b0);
    runInsn("R10 displacement wrap", 2, 1, 6, 0, 8'hF0, 1'b0);
    runInsn("R3 memory indirect", 6, 0, 3, 0, 8'h00, 1'b0);
    runInsn("R4 post-increment", 7, 4, 2, 0, 8'h00, 1'b0);
    runInsn("R5 pre-decrement",  8, 4, 2, 0, 8'h00, 1'b0);
    runInsn("R6 scaled",         9, 0, 1, 7, 8'h64, 1'b0);
    runInsn("R6 R10 scaled wrap", 9, 3, 6, 6, 8'hC8, 1'b0);
    runInsn("R10 post-increment wrap", 7, 1, 5, 0, 8'h00, 1'b0);
    runInsn("R7 post-increment dst alias", 7, 2, 2, 0, 8'h00, 1'b0);
    putReg(5, 8'h01);
    runInsn("R7 R10 pre-decrement dst alias", 8, 5, 5, 0, 8'h00, 1'b0);
    runInsn("R8 illegal code 10", 10, 1, 2, 3, 8'h11, 1'b0);
    runInsn("R8 illegal code 15", 15, 0, 0, 0, 8'hFF, 1'b0);
    runInsn("R9 start while busy (register)", 0, 6, 1, 2, 8'h00, 1'b1);
    runInsn("R9 start while busy (memory indirect)", 6, 3, 7, 0, 8'h00, 1'b1);
    runInsn("R9 start while busy (pre-decrement)", 8, 7, 2, 1, 8'h00, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule